// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is a single capture channel of a general-purpose timer. An asynchronous input pin is brought into the clock domain through a synchronizer chain. A selectable edge of the synchronized signal then copies the timer's free-running count, which the block receives as an input, into a capture register. Each capture raises a fresh-data flag. If a capture arrives while the previous value is still unread, a second flag records that data was lost.

Software reads the capture register through a read strobe, and that read consumes the fresh-data flag. Software clears either flag by writing a zero to the matching bit of a status write; writing a one leaves the flag as it is. A capture that lands in the same cycle as a bus read is arbitrated exactly. The new count is stored and reported as fresh. No loss is flagged, because the old value was delivered.

Top module: `cap_channel`

## Requirements
- R1: While reset is asserted and after it is released, the capture register reads 0 and the capture flag, the overcapture flag and the interrupt are all 0.
- R2: The edge mode selects the capture events: 2'b01 captures on rising edges, 2'b10 on falling edges, 2'b11 on both, and 2'b00 never captures. A level first sampled at clock edge k produces a capture at clock edge k+2, which stores the count present at that edge.
- R3: On a capture event, the count is stored in the capture register and the capture flag is set.
- R4: Without a capture event, the capture register keeps its value.
- R5: A read strobe that arrives with no capture in the same cycle clears the capture flag on the next clock.
- R6: A capture that arrives while the capture flag is set, with no read strobe in the same cycle, sets the overcapture flag.
- R7: When a capture and a read strobe arrive in the same cycle, the new count is stored, the capture flag ends up set and the overcapture flag is not set by that capture.
- R8: A status write clears the capture flag when data bit 0 is 0 and clears the overcapture flag when data bit 1 is 0. A data bit of 1 leaves its flag unchanged. A capture in the same cycle takes precedence over a clear of the capture flag.
- R9: The interrupt output is high exactly when the capture flag is set and the interrupt enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| capIn | input | 1 | Asynchronous capture input |
| counterVal | input | CNT_W | Timer count to be captured |
| edgeSel | input | 2 | Edge mode: 00 off, 01 rising, 10 falling, 11 both |
| irqEn | input | 1 | Interrupt enable |
| busRdCapt | input | 1 | One-cycle strobe: the bus reads the capture register |
| busWrStatus | input | 1 | One-cycle strobe: status write |
| busWrData | input | 2 | Status write data: bit 0 capture flag, bit 1 overcapture flag |
| capValue | output | CNT_W | Capture register contents |
| capFlag | output | 1 | Fresh capture available |
| overFlag | output | 1 | A capture overwrote an unread value |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a capture that coincides with a read of the capture register. The bus strobe must line up with the internal edge-detect cycle, which lies two synchronizer stages behind the pin. The stimulus toggles the pin on a falling clock edge and then waits exactly two more falling edges before it raises the read strobe for one cycle. That places the read in the capture cycle. The same alignment is reused to make a flag-clearing status write collide with a capture. The scoreboard predicts every stored count from the toggle time plus the synchronizer latency.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edgeMode_e;

  // Decisions handed from control to datapath each cycle
  typedef struct packed {
    logic load;
    logic setCap;
    logic clrCap;
    logic setOver;
    logic clrOver;
  } capStrobe_t;

endpackage

// File: rtl/cap_edge_detect.sv
module cap_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sigIn,
  input  logic [1:0] edgeSel,
  output logic       capEvent
);
  import cap_pkg::*;

  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain;
  logic synced, prevSynced, riseEdge, fallEdge;

  for (genvar i = 0; i < CHAIN_W; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) chain[i] <= 1'b0;
        else       chain[i] <= sigIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) chain[i] <= 1'b0;
        else       chain[i] <= chain[i-1];
      end
    end
  end

  assign synced     = chain[SYNC_STAGES-1];
  assign prevSynced = chain[SYNC_STAGES];
  assign riseEdge   = synced & ~prevSynced;
  assign fallEdge   = ~synced & prevSynced;

  always_comb begin
    unique case (edgeMode_e'(edgeSel))
      EDGE_RISE: capEvent = riseEdge;
      EDGE_FALL: capEvent = fallEdge;
      EDGE_BOTH: capEvent = riseEdge | fallEdge;
      default:   capEvent = 1'b0;
    endcase
  end
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl (
  input  logic                capEvent,
  input  logic                rdCapt,
  input  logic                wrStatus,
  input  logic [1:0]          wrData,
  input  logic                capFlag,
  output cap_pkg::capStrobe_t strobe
);
  always_comb begin
    strobe.load    = capEvent;
    strobe.setCap  = capEvent;
    // a read or zero write consumes the flag unless fresh data arrives now
    strobe.clrCap  = (rdCapt | (wrStatus & ~wrData[0])) & ~capEvent;
    // data lost only if the pending value is not being delivered this cycle
    strobe.setOver = capEvent & capFlag & ~rdCapt;
    strobe.clrOver = wrStatus & ~wrData[1];
  end
endmodule

// File: rtl/cap_datapath.sv
module cap_datapath #(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CNT_W-1:0]    counterVal,
  input  cap_pkg::capStrobe_t strobe,
  output logic [CNT_W-1:0]    capReg,
  output logic                capFlag,
  output logic                overFlag
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capReg   <= '0;
      capFlag  <= 1'b0;
      overFlag <= 1'b0;
    end else begin
      if (strobe.load) capReg <= counterVal;

      if (strobe.setCap)      capFlag <= 1'b1;
      else if (strobe.clrCap) capFlag <= 1'b0;

      if (strobe.setOver)      overFlag <= 1'b1;
      else if (strobe.clrOver) overFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/cap_channel.sv
module cap_channel #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             capIn,
  input  logic [CNT_W-1:0] counterVal,
  input  logic [1:0]       edgeSel,
  input  logic             irqEn,
  input  logic             busRdCapt,
  input  logic             busWrStatus,
  input  logic [1:0]       busWrData,
  output logic [CNT_W-1:0] capValue,
  output logic             capFlag,
  output logic             overFlag,
  output logic             irq
);
  cap_pkg::capStrobe_t strobe;
  logic capEvent;

  cap_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk(clk), .rstN(rstN), .sigIn(capIn), .edgeSel(edgeSel), .capEvent(capEvent)
  );

  cap_ctrl ctrl_i (
    .capEvent(capEvent), .rdCapt(busRdCapt), .wrStatus(busWrStatus),
    .wrData(busWrData), .capFlag(capFlag), .strobe(strobe)
  );

  cap_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .counterVal(counterVal), .strobe(strobe),
    .capReg(capValue), .capFlag(capFlag), .overFlag(overFlag)
  );

  assign irq = capFlag & irqEn;
endmodule

// File: rtl/cap_channel_chk.sv
module cap_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             capEvent,
  input logic [CNT_W-1:0] counterVal,
  input logic [CNT_W-1:0] capValue,
  input logic             capFlag,
  input logic             overFlag,
  input logic             busRdCapt,
  input logic             busWrStatus,
  input logic [1:0]       busWrData,
  input logic             irqEn,
  input logic             irq
);
  // R3: stored count and flag after a capture
  a_r3_stores_count: assert property (@(posedge clk) disable iff (!rstN)
    capEvent |=> (capValue == $past(counterVal)) && capFlag);

  // R4: register holds without an event
  a_r4_holds_value: assert property (@(posedge clk) disable iff (!rstN)
    !capEvent |=> $stable(capValue));

  // R5: read consumes the flag
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (busRdCapt && !capEvent) |=> !capFlag);

  // R6: unread value overwritten
  a_r6_overcapture: assert property (@(posedge clk) disable iff (!rstN)
    (capEvent && capFlag && !busRdCapt) |=> overFlag);

  // R7: coincident read and capture
  a_r7_coincide: assert property (@(posedge clk) disable iff (!rstN)
    (capEvent && busRdCapt && !overFlag) |=> capFlag && !overFlag);

  // R8: writing ones changes nothing
  a_r8_ones_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busWrStatus && busWrData == 2'b11 && !capEvent && !busRdCapt)
      |=> $stable(capFlag) && $stable(overFlag));

  // R9: interrupt gated by enable
  a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !irq);
endmodule

bind cap_channel cap_channel_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .capEvent(capEvent), .counterVal(counterVal),
  .capValue(capValue), .capFlag(capFlag), .overFlag(overFlag),
  .busRdCapt(busRdCapt), .busWrStatus(busWrStatus), .busWrData(busWrData),
  .irqEn(irqEn), .irq(irq)
);

// File: tb/cap_channel_tb.sv
module cap_channel_tb_top;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic capIn = 1'b0;
  logic [CNT_W-1:0] cnt = '0;
  logic [1:0] edgeSel = 2'b00;
  logic irqEn = 1'b0;
  logic busRdCapt = 1'b0;
  logic busWrStatus = 1'b0;
  logic [1:0] busWrData = 2'b11;
  logic [CNT_W-1:0] capValue;
  logic capFlag, overFlag, irq;

  int nChecks = 0;
  int nFails  = 0;
  logic [CNT_W-1:0] expQ[$];
  logic [CNT_W-1:0] lastVal = '0;
  logic [CNT_W-1:0] heldVal;

  always #2.5 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 1'b1;

  cap_channel #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .capIn(capIn), .counterVal(cnt), .edgeSel(edgeSel),
    .irqEn(irqEn), .busRdCapt(busRdCapt), .busWrStatus(busWrStatus),
    .busWrData(busWrData), .capValue(capValue), .capFlag(capFlag),
    .overFlag(overFlag), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: every change of the capture register must match the scoreboard
  always @(negedge clk) begin
    if (rstN && capValue !== lastVal) begin
      if (expQ.size() == 0) check("R4 unexpected capture", 32'(capValue), 32'(lastVal));
      else check("R3 captured count", 32'(capValue), 32'(expQ.pop_front()));
      lastVal = capValue;
    end
  end

  // Driver: change the pin; a capture, if expected, stores cnt+2
  task automatic drivePin(logic lvl, bit expectCap);
    @(negedge clk);
    capIn = lvl;
    if (expectCap) expQ.push_back(cnt + 16'd2);
    repeat (3) @(negedge clk);
  endtask

  // Pin change with a bus action aligned to the capture cycle
  task automatic drivePinAligned(logic lvl, bit doRead, bit doWrite, logic [1:0] wd);
    @(negedge clk);
    capIn = lvl;
    expQ.push_back(cnt + 16'd2);
    repeat (2) @(negedge clk);
    busRdCapt = doRead;
    busWrStatus = doWrite;
    busWrData = wd;
    @(negedge clk);
    busRdCapt = 1'b0;
    busWrStatus = 1'b0;
    busWrData = 2'b11;
  endtask

  task automatic busRead();
    @(negedge clk); busRdCapt = 1'b1;
    @(negedge clk); busRdCapt = 1'b0;
  endtask

  task automatic busWrite(logic [1:0] d);
    @(negedge clk); busWrStatus = 1'b1; busWrData = d;
    @(negedge clk); busWrStatus = 1'b0; busWrData = 2'b11;
  endtask

  initial begin
    #(5 * 100000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 capValue in reset", 32'(capValue), 0);
    check("R1 capFlag in reset", 32'(capFlag), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 overFlag after reset", 32'(overFlag), 0);
    check("R1 irq after reset", 32'(irq), 0);

    // rising mode
    edgeSel = 2'b01;
    drivePin(1'b1, 1'b1);
    check("R3 capFlag set", 32'(capFlag), 1);
    check("R9 irq masked", 32'(irq), 0);
    heldVal = capValue;
    drivePin(1'b0, 1'b0);
    check("R2 falling ignored in rising mode", 32'(capValue), 32'(heldVal));
    check("R6 no overcapture yet", 32'(overFlag), 0);
    busRead();
    check("R5 read clears capFlag", 32'(capFlag), 0);

    // falling mode
    edgeSel = 2'b10;
    drivePin(1'b1, 1'b0);
    check("R2 rising ignored in falling mode", 32'(capFlag), 0);
    drivePin(1'b0, 1'b1);
    check("R2 falling captured", 32'(capFlag), 1);

    // second capture with unread value
    edgeSel = 2'b11;
    irqEn = 1'b1;
    drivePin(1'b1, 1'b1);
    check("R6 overcapture set", 32'(overFlag), 1);
    check("R9 irq asserted", 32'(irq), 1);

    // status writes
    busWrite(2'b11);
    check("R8 ones keep capFlag", 32'(capFlag), 1);
    check("R8 ones keep overFlag", 32'(overFlag), 1);
    busWrite(2'b10);
    check("R8 bit0 zero clears capFlag", 32'(capFlag), 0);
    check("R8 overFlag kept", 32'(overFlag), 1);
    check("R9 irq follows flag", 32'(irq), 0);
    busWrite(2'b01);
    check("R8 bit1 zero clears overFlag", 32'(overFlag), 0);

    // both edges
    drivePin(1'b0, 1'b1);
    check("R2 both mode falling", 32'(capFlag), 1);
    busRead();
    drivePin(1'b1, 1'b1);
    check("R2 both mode rising", 32'(capFlag), 1);
    busRead();

    // disabled
    edgeSel = 2'b00;
    heldVal = capValue;
    drivePin(1'b0, 1'b0);
    drivePin(1'b1, 1'b0);
    check("R2 off mode no capture", 32'(capValue), 32'(heldVal));
    check("R2 off mode flag clear", 32'(capFlag), 0);

    // coincident read and capture with flag already set
    edgeSel = 2'b11;
    drivePin(1'b0, 1'b1);
    drivePinAligned(1'b1, 1'b1, 1'b0, 2'b11);
    check("R7 capFlag stays set", 32'(capFlag), 1);
    check("R7 no overcapture", 32'(overFlag), 0);

    // coincident clear-write and capture
    drivePinAligned(1'b0, 1'b0, 1'b1, 2'b10);
    check("R8 capture wins over clear", 32'(capFlag), 1);
    check("R6 unread value lost", 32'(overFlag), 1);

    repeat (2) @(negedge clk);
    check("R3 scoreboard drained", 32'(expQ.size()), 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule